// File: doc/BRIEF.md
# Per-CPU Local Interrupt Router

This block collects the interrupt lines that belong to a small cluster of CPUs and turns them into one IRQ and one FIQ request per CPU. Each CPU has ten local sources: four timer lines, four mailbox lines, the shared GPU line and its own PMU line. Software decides where each source goes. Per-CPU control words pick IRQ or FIQ for each timer and mailbox line. A routing word sends the single GPU line to one CPU. A pair of write-one-to-set and write-one-to-clear addresses gates the PMU line of each CPU.

The pending view is purely combinational. A CPU's interrupt handler reads its IRQ or FIQ pending word and sees the live level of every source that is currently steered to that request type. The mailbox storage and the timer comparators sit outside the block. They only present level lines here.

Top module: `local_irq_router`

## Requirements
- R1: After reset every timer and mailbox enable is zero, every PMU enable is zero, and the GPU routing word reads 0 (IRQ to CPU 0, FIQ route off). With all sources low, every pending word and every irq_o/fiq_o bit is 0.
- R2: The timer control word of CPU c is at byte offset 0x40+4c. Bits [3:0] are IRQ enables and bits [7:4] are FIQ enables for timer lines 0..3. An enabled, asserted timer line t shows as pending bit t. It goes to FIQ pending when its FIQ enable is set, whatever its IRQ enable is. Otherwise it goes to IRQ pending when its IRQ enable is set.
- R3: The mailbox control word of CPU c is at 0x50+4c and has the same layout as the timer word. Mailbox line m shows as pending bit 4+m, with FIQ taking precedence over IRQ.
- R4: The GPU routing word is at 0x0C. Bits [1:0] select the IRQ target CPU, bits [3:2] select the FIQ target CPU, and bit 4 turns the FIQ route on. With bit 4 clear, an asserted GPU line sets IRQ pending bit 8 of the IRQ target CPU only.
- R5: With routing bit 4 set, an asserted GPU line sets FIQ pending bit 8 of the FIQ target CPU only. It then appears in no IRQ pending word.
- R6: Writing to 0x10 sets the PMU enable of every CPU whose data bit (0..3) is 1. Writing to 0x14 clears those enables. Zero data bits leave enables unchanged, and reading 0x10 returns the enable mask. An enabled CPU with its PMU line high shows IRQ pending bit 9.
- R7: irq_o[c] is high exactly when CPU c's IRQ pending word is nonzero. fiq_o[c] is high exactly when its FIQ pending word is nonzero.
- R8: No source is ever pending in both the IRQ and FIQ word of the same CPU.
- R9: The IRQ pending words (0x60+4c) and FIQ pending words (0x70+4c) follow the current source levels without latching. Writes to these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| timer_i | input | 16 | Timer lines, 4 per CPU, CPU c at [4c+3:4c] |
| mbox_i | input | 16 | Mailbox lines, 4 per CPU, CPU c at [4c+3:4c] |
| gpu_i | input | 1 | Shared GPU interrupt line |
| pmu_i | input | 4 | PMU line per CPU |
| irq_o | output | 4 | IRQ request per CPU |
| fiq_o | output | 4 | FIQ request per CPU |

## Verification
The bench builds the router with its default of four CPUs. This is the full width of the 2-bit GPU target fields, so every routing target, including CPU 3, can be reached. The vector table cycles through all four CPUs' control words and shows that one CPU's enables never leak into another. The directed tests move the GPU line between IRQ and FIQ targets, step the PMU mask through set and clear writes, and write to the read-only pending addresses.

// File: rtl/lir_pkg.sv
package lir_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int GRP_W   = 4;
    localparam int PEND_W  = 10;
    localparam int MBOX_LO = 4;
    localparam int GPU_BIT = 8;
    localparam int PMU_BIT = 9;

    localparam logic [ADDR_W-1:0] OFF_ROUTE   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PMU_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_PMU_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TCTL    = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_MCTL    = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_IPEND   = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_FPEND   = 8'h70;

    typedef struct packed {
        logic [GRP_W-1:0] fiq;
        logic [GRP_W-1:0] irq;
    } src_ctl_t;

    typedef struct packed {
        logic       fiq_on;
        logic [1:0] fiq_cpu;
        logic [1:0] irq_cpu;
    } gpu_route_t;

    localparam gpu_route_t ROUTE_RST = '{fiq_on: 1'b0, fiq_cpu: 2'd0, irq_cpu: 2'd0};

    // Steer one group of lines: FIQ enable wins over IRQ enable.
    function automatic logic [2*GRP_W-1:0] steer_grp(logic [GRP_W-1:0] lines, src_ctl_t ctl);
        logic [GRP_W-1:0] to_f;
        logic [GRP_W-1:0] to_i;
        to_f = lines & ctl.fiq;
        to_i = lines & ctl.irq & ~ctl.fiq;
        return {to_f, to_i};
    endfunction
endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output src_ctl_t          tctl_q [NCPU],
    output src_ctl_t          mctl_q [NCPU],
    output gpu_route_t        route_q,
    output logic [NCPU-1:0]   pmu_en_q
);
    logic [NCPU-1:0] set_m;
    logic [NCPU-1:0] clr_m;

    assign set_m = (wr_en && wr_addr == OFF_PMU_SET) ? wr_data[NCPU-1:0] : '0;
    assign clr_m = (wr_en && wr_addr == OFF_PMU_CLR) ? wr_data[NCPU-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q  <= ROUTE_RST;
            pmu_en_q <= '0;
        end else begin
            if (wr_en && wr_addr == OFF_ROUTE)
                route_q <= gpu_route_t'(wr_data[4:0]);
            pmu_en_q <= (pmu_en_q | set_m) & ~clr_m;
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_ctl
        localparam logic [ADDR_W-1:0] T_ADDR = OFF_TCTL + ADDR_W'(4 * c);
        localparam logic [ADDR_W-1:0] M_ADDR = OFF_MCTL + ADDR_W'(4 * c);
        always_ff @(posedge clk) begin
            if (rst) begin
                tctl_q[c] <= '0;
                mctl_q[c] <= '0;
            end else if (wr_en) begin
                if (wr_addr == T_ADDR) tctl_q[c] <= src_ctl_t'(wr_data[7:0]);
                if (wr_addr == M_ADDR) mctl_q[c] <= src_ctl_t'(wr_data[7:0]);
            end
        end
    end
endmodule

// File: rtl/lir_cpu_route.sv
module lir_cpu_route
    import lir_pkg::*;
#(
    parameter int CPU_ID = 0
) (
    input  logic [GRP_W-1:0]  timer_i,
    input  logic [GRP_W-1:0]  mbox_i,
    input  logic              gpu_i,
    input  logic              pmu_i,
    input  src_ctl_t          tctl,
    input  src_ctl_t          mctl,
    input  gpu_route_t        route,
    input  logic              pmu_en,
    output logic [PEND_W-1:0] ipend,
    output logic [PEND_W-1:0] fpend
);
    localparam logic [1:0] ME = 2'(CPU_ID);

    logic [2*GRP_W-1:0] t_st;
    logic [2*GRP_W-1:0] m_st;
    logic               gpu_f;
    logic               gpu_i_here;

    always_comb begin
        t_st       = steer_grp(timer_i, tctl);
        m_st       = steer_grp(mbox_i, mctl);
        gpu_f      = gpu_i && route.fiq_on && route.fiq_cpu == ME;
        gpu_i_here = gpu_i && !route.fiq_on && route.irq_cpu == ME;

        ipend = {pmu_i & pmu_en, gpu_i_here, m_st[GRP_W-1:0], t_st[GRP_W-1:0]};
        fpend = {1'b0, gpu_f, m_st[2*GRP_W-1:GRP_W], t_st[2*GRP_W-1:GRP_W]};
    end
endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
    import lir_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NCPU*GRP_W-1:0] timer_i,
    input  logic [NCPU*GRP_W-1:0] mbox_i,
    input  logic                  gpu_i,
    input  logic [NCPU-1:0]       pmu_i,
    output logic [NCPU-1:0]       irq_o,
    output logic [NCPU-1:0]       fiq_o
);
    localparam int FLAT_W = NCPU * PEND_W;

    src_ctl_t          tctl_q [NCPU];
    src_ctl_t          mctl_q [NCPU];
    gpu_route_t        route_q;
    logic [NCPU-1:0]   pmu_en_q;
    logic [PEND_W-1:0] ipend [NCPU];
    logic [PEND_W-1:0] fpend [NCPU];
    logic [FLAT_W-1:0] ipend_flat;
    logic [FLAT_W-1:0] fpend_flat;

    lir_regs #(.NCPU(NCPU)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tctl_q  (tctl_q),
        .mctl_q  (mctl_q),
        .route_q (route_q),
        .pmu_en_q(pmu_en_q)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        lir_cpu_route #(.CPU_ID(c)) route_i (
            .timer_i(timer_i[c*GRP_W +: GRP_W]),
            .mbox_i (mbox_i[c*GRP_W +: GRP_W]),
            .gpu_i  (gpu_i),
            .pmu_i  (pmu_i[c]),
            .tctl   (tctl_q[c]),
            .mctl   (mctl_q[c]),
            .route  (route_q),
            .pmu_en (pmu_en_q[c]),
            .ipend  (ipend[c]),
            .fpend  (fpend[c])
        );
        assign irq_o[c] = |ipend[c];
        assign fiq_o[c] = |fpend[c];
        assign ipend_flat[c*PEND_W +: PEND_W] = ipend[c];
        assign fpend_flat[c*PEND_W +: PEND_W] = fpend[c];
    end

    // Read mux: per-CPU words are grouped by the upper nibble, CPU by bits [3:2].
    logic [ADDR_W-1:0] rd_base;
    logic [1:0]        rd_cpu;
    logic              rd_cpu_ok;

    always_comb begin
        rd_base   = {rd_addr[ADDR_W-1:4], 4'h0};
        rd_cpu    = rd_addr[3:2];
        rd_cpu_ok = (32'(rd_cpu) < NCPU) && (rd_addr[1:0] == 2'b00);
        rd_data   = '0;
        if (rd_addr == OFF_ROUTE) begin
            rd_data[4:0] = route_q;
        end else if (rd_addr == OFF_PMU_SET) begin
            rd_data[NCPU-1:0] = pmu_en_q;
        end else if (rd_cpu_ok) begin
            case (rd_base)
                OFF_TCTL:  rd_data[7:0]        = tctl_q[rd_cpu];
                OFF_MCTL:  rd_data[7:0]        = mctl_q[rd_cpu];
                OFF_IPEND: rd_data[PEND_W-1:0] = ipend[rd_cpu];
                OFF_FPEND: rd_data[PEND_W-1:0] = fpend[rd_cpu];
                default:   rd_data             = '0;
            endcase
        end
    end
endmodule

// File: rtl/local_irq_router_chk.sv
module local_irq_router_chk
    import lir_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     gpu_i,
    input logic [NCPU*GRP_W-1:0]    timer_i,
    input logic [NCPU*GRP_W-1:0]    mbox_i,
    input logic [NCPU-1:0]          pmu_i,
    input logic [NCPU-1:0]          irq_o,
    input logic [NCPU-1:0]          fiq_o,
    input logic [4:0]               route_bits,
    input logic [NCPU-1:0]          pmu_en,
    input logic [NCPU*PEND_W-1:0]   ipend_flat,
    input logic [NCPU*PEND_W-1:0]   fpend_flat
);
    logic [NCPU-1:0] gpu_irq_hits;
    logic [NCPU-1:0] gpu_fiq_hits;
    for (genvar c = 0; c < NCPU; c++) begin : g_hits
        assign gpu_irq_hits[c] = ipend_flat[c*PEND_W + GPU_BIT];
        assign gpu_fiq_hits[c] = fpend_flat[c*PEND_W + GPU_BIT];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (route_bits == 5'd0 && pmu_en == '0));

    // R6
    pmu_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFF_PMU_SET) |=> ((pmu_en & $past(wr_data[NCPU-1:0])) == $past(wr_data[NCPU-1:0])));

    // R6
    pmu_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFF_PMU_CLR) |=> ((pmu_en & $past(wr_data[NCPU-1:0])) == '0));

    // R4
    gpu_irq_one_chk: assert property (@(posedge clk) disable iff (rst)
        (gpu_i && !route_bits[4]) |-> ($countones(gpu_irq_hits) == 1 && gpu_fiq_hits == '0));

    // R5
    gpu_fiq_one_chk: assert property (@(posedge clk) disable iff (rst)
        (gpu_i && route_bits[4]) |-> ($countones(gpu_fiq_hits) == 1 && gpu_irq_hits == '0));

    // R9
    gpu_level_chk: assert property (@(posedge clk) disable iff (rst)
        !gpu_i |-> (gpu_irq_hits == '0 && gpu_fiq_hits == '0));

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
        // R8
        no_dual_chk: assert property (@(posedge clk) disable iff (rst)
            (ipend_flat[c*PEND_W +: PEND_W] & fpend_flat[c*PEND_W +: PEND_W]) == '0);

        // R7
        irq_src_chk: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] |-> (timer_i[c*GRP_W +: GRP_W] != '0 || mbox_i[c*GRP_W +: GRP_W] != '0
                          || gpu_i || pmu_i[c]));

        // R7
        fiq_src_chk: assert property (@(posedge clk) disable iff (rst)
            fiq_o[c] |-> (timer_i[c*GRP_W +: GRP_W] != '0 || mbox_i[c*GRP_W +: GRP_W] != '0 || gpu_i));
    end
endmodule

bind local_irq_router local_irq_router_chk #(.NCPU(NCPU)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .gpu_i     (gpu_i),
    .timer_i   (timer_i),
    .mbox_i    (mbox_i),
    .pmu_i     (pmu_i),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .route_bits(route_q),
    .pmu_en    (pmu_en_q),
    .ipend_flat(ipend_flat),
    .fpend_flat(fpend_flat)
);

// File: tb/local_irq_router_tb.sv
module local_irq_router_tb_top;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] timer_i = '0;
    logic [15:0] mbox_i = '0;
    logic        gpu_i = 1'b0;
    logic [3:0]  pmu_i = '0;
    logic [3:0]  irq_o;
    logic [3:0]  fiq_o;

    int applied = 0;
    int errors  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    local_irq_router #(.NCPU(NCPU)) dut_i (.*);

    // {timer ctl, mbox ctl, timer lines, mbox lines, exp irq pend, exp fiq pend}
    localparam logic [43:0] VEC [8] = '{
        {8'h0F, 8'h00, 4'hF, 4'h0, 10'h00F, 10'h000},
        {8'hF0, 8'h00, 4'h5, 4'h0, 10'h000, 10'h005},
        {8'h33, 8'h00, 4'hF, 4'h0, 10'h000, 10'h003},
        {8'h2C, 8'h00, 4'hE, 4'h0, 10'h00C, 10'h002},
        {8'h00, 8'h0F, 4'h0, 4'h9, 10'h090, 10'h000},
        {8'h00, 8'h81, 4'h0, 4'hF, 10'h010, 10'h080},
        {8'h01, 8'h10, 4'h1, 4'h1, 10'h001, 10'h010},
        {8'hFF, 8'hFF, 4'h0, 4'h0, 10'h000, 10'h000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h0C, v);  check("R1 route", v, 32'h0);
        rd(8'h10, v);  check("R1 pmu mask", v, 32'h0);
        rd(8'h44, v);  check("R1 timer ctl", v, 32'h0);
        rd(8'h6C, v);  check("R1 irq pend", v, 32'h0);
        check("R1 outputs", {28'h0, irq_o | fiq_o}, 32'h0);

        // R2 R3 R7 R8: table walk across all CPUs
        for (int i = 0; i < 8; i++) begin
            int c;
            c = i % NCPU;
            wr(8'h40 + 8'(4 * c), {24'h0, VEC[i][43:36]});
            wr(8'h50 + 8'(4 * c), {24'h0, VEC[i][35:28]});
            @(negedge clk);
            timer_i = '0; mbox_i = '0;
            timer_i[c*4 +: 4] = VEC[i][27:24];
            mbox_i[c*4 +: 4]  = VEC[i][23:20];
            rd(8'h60 + 8'(4 * c), v); check("R2/R3 irq pend", v, {22'h0, VEC[i][19:10]});
            rd(8'h70 + 8'(4 * c), v); check("R2/R3 fiq pend", v, {22'h0, VEC[i][9:0]});
            check("R7 irq_o", {31'h0, irq_o[c]}, {31'h0, VEC[i][19:10] != 0});
            check("R7 fiq_o", {31'h0, fiq_o[c]}, {31'h0, VEC[i][9:0] != 0});
        end
        timer_i = '0; mbox_i = '0;

        // R4: GPU to IRQ of CPU 0, then CPU 2
        gpu_i = 1'b1;
        rd(8'h60, v); check("R4 gpu cpu0", v, 32'h100);
        wr(8'h0C, 32'h02);
        rd(8'h68, v); check("R4 gpu cpu2", v, 32'h100);
        rd(8'h60, v); check("R4 gpu not cpu0", v, 32'h0);

        // R5: FIQ route to CPU 3 overrides IRQ route
        wr(8'h0C, 32'h1E);
        rd(8'h7C, v); check("R5 gpu fiq cpu3", v, 32'h100);
        rd(8'h68, v); check("R5 gpu not irq", v, 32'h0);
        check("R5 fiq_o", {28'h0, fiq_o}, 32'h8);
        gpu_i = 1'b0;
        rd(8'h7C, v); check("R9 gpu level", v, 32'h0);

        // R6: PMU set/clear
        wr(8'h10, 32'h5);
        rd(8'h10, v); check("R6 set", v, 32'h5);
        pmu_i = 4'hF;
        rd(8'h60, v); check("R6 pmu cpu0", v, 32'h200);
        rd(8'h64, v); check("R6 pmu cpu1 off", v, 32'h0);
        wr(8'h14, 32'h1);
        rd(8'h10, v); check("R6 clear", v, 32'h4);
        rd(8'h60, v); check("R6 cpu0 cleared", v, 32'h0);
        rd(8'h68, v); check("R6 cpu2 kept", v, 32'h200);

        // R9: pending words ignore writes
        wr(8'h68, 32'h0);
        wr(8'h70, 32'h3FF);
        rd(8'h68, v); check("R9 irq pend write", v, 32'h200);
        rd(8'h70, v); check("R9 fiq pend write", v, 32'h0);
        pmu_i = 4'h0;
        rd(8'h68, v); check("R9 pmu level", v, 32'h0);

        done = 1;
    end

    initial begin
        for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
        if (!done) begin
            errors++;
            applied++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule